// File: doc/BRIEF.md
# Paced UART Transmit Queue

This block sits between a one-word host write buffer and the parallel load port of a UART transmit shift register. In direct mode it behaves like a plain UART: a word written by the host goes into the shift register as soon as the shifter says it is idle. When queue mode is enabled, host words first pass into a four-entry, eight-bit FIFO. The shift register is then fed only from the head of that FIFO.

A programmable gap, counted in baud ticks, separates successive words taken from the FIFO. This lets a fast host talk to a slow receiver without software pacing. A gap of zero gives continuous back-to-back output. The block reports its fill level and raises a transmit interrupt while the fill is at or below a programmable level. A queue-run control holds the FIFO empty while it is low.

The serial shifter and the baud generator are outside the block. The shifter reports its idle state on `sh_ready`, and the baud generator supplies a one-cycle `tick`.

Top module: `uart_tx_pacer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `fill` is 0, `sh_load` is 0, `ovf_pulse` is 0 and `tx_irq` is 1. After reset the block is in direct mode with an empty host buffer.
- R2: With `q_en`=0, a held host word is presented on `sh_data` with `sh_load`=1 in any cycle where `sh_ready`=1. The host buffer is empty after that edge.
- R3: With `q_en`=1, the shift register is loaded only from the FIFO head, in write order. `sh_load` never asserts while `sh_ready`=0. The host word moves into the FIFO only in a cycle with `sh_ready`=1 and `q_run`=1.
- R4: The FIFO holds 4 words. If a host word arrives while the FIFO is full and no word leaves in the same cycle, the word is dropped. In that case `ovf_pulse` is 1 for that cycle and `fill` does not change.
- R5: After a queue-mode load, the next queue-mode load waits until `gap_cfg` ticks have been counted and `sh_ready`=1. With `gap_cfg`=0, a load may occur in every cycle where `sh_ready`=1.
- R6: `fill` gives the number of words held in the FIFO, zero-extended to 5 bits.
- R7: While `q_run`=0 there is no queue transfer. From the next cycle `fill` reads 0, and when `q_run` returns to 1 the queue restarts from empty.
- R8: With `q_en`=1, `tx_irq` is 1 exactly when `fill` <= `trig_lvl`.
- R9: With `q_en`=0, `tx_irq` is 1 exactly when the host buffer is empty.
- R10: A host write in the same cycle the buffer is drained, or while it is still full, replaces the buffer content. The last word written is the one sent.
- R11: Clearing `q_en` discards the FIFO contents, so `fill` reads 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low module reset |
| q_en | input | 1 | 1 selects queue mode, 0 selects direct mode |
| q_run | input | 1 | 0 holds the FIFO pointers at zero |
| gap_cfg | input | 8 | Baud ticks between queue-mode loads |
| trig_lvl | input | 5 | Interrupt fill threshold |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| tick | input | 1 | Baud tick, one cycle wide |
| sh_ready | input | 1 | Shifter idle, last bit sent |
| sh_load | output | 1 | Load strobe to the shift register |
| sh_data | output | 8 | Word for the shift register |
| fill | output | 5 | FIFO word count |
| tx_irq | output | 1 | Transmit interrupt |
| ovf_pulse | output | 1 | Word dropped on a full FIFO |

## Verification
The assertions assume a synchronous reset and inputs that change away from the active edge. They do not assume any protocol from the shifter: `sh_ready` may rise and fall freely, because the queue must stay correct for any idle pattern. The stimulus holds the mode, gap and threshold settings fixed across bursts of cycles and changes them only between bursts. Within a burst, writes, ticks, shifter idle and the run control vary at random. Directed sequences drive the full FIFO, a long gap with no ticks, and a mode switch with words still queued.

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int GAPW  = 8,
  parameter int LVLW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q_en,
  input  logic            q_run,
  input  logic [GAPW-1:0] gap_cfg,
  input  logic [LVLW-1:0] trig_lvl,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  input  logic            tick,
  input  logic            sh_ready,
  output logic            sh_load,
  output logic [DW-1:0]   sh_data,
  output logic [LVLW-1:0] fill,
  output logic            tx_irq,
  output logic            ovf_pulse
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0]   hb_data;
  logic            hb_full;
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   count;
  logic [GAPW-1:0] gap_cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire q_live   = q_en & q_run;
  wire q_full   = (count == CW'(DEPTH));
  wire pop      = q_live & sh_ready & (gap_cnt == '0) & (count != '0);
  wire push_try = q_live & hb_full & sh_ready;
  wire push     = push_try & (~q_full | pop);
  wire hb_drain = q_en ? push_try : (hb_full & sh_ready);

  assign ovf_pulse = push_try & q_full & ~pop;
  assign sh_load   = q_en ? pop : (hb_full & sh_ready);
  assign sh_data   = q_en ? mem[rd_ptr] : hb_data;
  assign fill      = LVLW'(count);
  assign tx_irq    = q_en ? (fill <= trig_lvl) : ~hb_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_full <= 1'b0;
      hb_data <= '0;
    end else if (wr_valid) begin
      hb_full <= 1'b1;
      hb_data <= wr_data;
    end else if (hb_drain) begin
      hb_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= hb_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !q_live) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push) wr_ptr <= bump(wr_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     gap_cnt <= '0;
    else if (pop)                   gap_cnt <= gap_cfg;
    else if (tick && gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
  end

  assert_load_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> sh_ready);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LVLW'(DEPTH));
  assert_drop_keeps_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> fill == $past(fill));
  assert_gap_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && sh_load && gap_cfg != '0) |=> !(q_en && sh_load));
  assert_run_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !q_run |=> fill == '0);
  assert_empty_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && fill == '0) |-> tx_irq);
  assert_mode_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |=> fill == '0);
endmodule

// File: tb/uart_tx_pacer_tb_top.sv
`timescale 1ns/1ps
module uart_tx_pacer_tb_top;
  logic clk = 0, rst_n = 0;
  logic q_en = 0, q_run = 1, wr_valid = 0, tick = 0, sh_ready = 0;
  logic [7:0] gap_cfg = 0, wr_data = 0, sh_data;
  logic [4:0] trig_lvl = 0, fill;
  logic sh_load, tx_irq, ovf_pulse;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_tx_pacer dut_i (.clk(clk), .rst_n(rst_n), .q_en(q_en), .q_run(q_run),
    .gap_cfg(gap_cfg), .trig_lvl(trig_lvl), .wr_valid(wr_valid), .wr_data(wr_data),
    .tick(tick), .sh_ready(sh_ready), .sh_load(sh_load), .sh_data(sh_data),
    .fill(fill), .tx_irq(tx_irq), .ovf_pulse(ovf_pulse));

  logic [7:0] q[$];
  logic m_hbf = 0;
  logic [7:0] m_hbd = 0;
  int m_gap = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_irq(input logic en, input logic [4:0] tl);
    if (en) return (q.size() <= tl) ? 1 : 0;
    return m_hbf ? 0 : 1;
  endfunction

  task automatic step(input logic en, run, wr, input logic [7:0] wd,
                      input logic rdy, tk, input logic [7:0] gc, input logic [4:0] tl);
    logic pop, ptry, ovf, ld, drain;
    logic [7:0] d;
    @(negedge clk);
    q_en = en; q_run = run; wr_valid = wr; wr_data = wd; sh_ready = rdy;
    tick = tk; gap_cfg = gc; trig_lvl = tl;
    #1;
    pop  = en && run && rdy && m_gap == 0 && q.size() > 0;
    ptry = en && run && m_hbf && rdy;
    ovf  = ptry && q.size() == 4 && !pop;
    ld   = en ? pop : (m_hbf && rdy);
    d    = en ? (pop ? q[0] : 8'h00) : m_hbd;
    chk(en ? (m_gap != 0 ? "R5 load" : "R3 load") : "R2 load", sh_load, ld);
    if (ld) chk(en ? "R3 data" : "R2 data", sh_data, d);
    chk("R6 fill", fill, q.size());
    chk(en ? "R8 irq" : "R9 irq", tx_irq, exp_irq(en, tl));
    chk("R4 ovf", ovf_pulse, ovf);
    drain = en ? ptry : (m_hbf && rdy);
    if (pop) void'(q.pop_front());
    if (ptry && !ovf) q.push_back(m_hbd);
    if (!en || !run) q.delete();
    if (pop) m_gap = gc; else if (tk && m_gap > 0) m_gap--;
    if (wr) begin m_hbf = 1; m_hbd = wd; end
    else if (drain) m_hbf = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 fill", fill, 0); chk("R1 load", sh_load, 0);
    chk("R1 irq", tx_irq, 1); chk("R1 ovf", ovf_pulse, 0);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 irq after", tx_irq, 1); chk("R1 fill after", fill, 0);

    step(0, 1, 1, 8'hA1, 0, 0, 0, 0);
    step(0, 1, 1, 8'hB2, 0, 0, 0, 0);
    step(0, 1, 0, 8'h00, 1, 0, 0, 0);
    chk("R10 last word sent", sh_data, 8'hB2);
    step(0, 1, 0, 8'h00, 1, 0, 0, 0);
    chk("R9 irq after drain", tx_irq, 1);

    step(1, 1, 1, 8'h11, 0, 0, 3, 2);
    step(1, 1, 0, 8'h00, 1, 0, 3, 2);
    step(1, 1, 1, 8'h22, 1, 0, 3, 2);
    chk("R3 head to shifter", sh_data, 8'h11);
    step(1, 1, 0, 8'h00, 1, 0, 3, 2);
    chk("R5 held during gap", sh_load, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 8'h00, 0, 1, 3, 2);
    step(1, 1, 0, 8'h00, 1, 0, 3, 2);
    chk("R5 load after gap", sh_load, 1);
    chk("R5 data after gap", sh_data, 8'h22);

    for (int i = 0; i < 6; i++) step(1, 1, 1, 8'h30 + 8'(i), 1, 0, 255, 1);
    step(1, 1, 0, 8'h00, 1, 0, 255, 1);
    chk("R4 full depth", fill, 4);
    step(0, 1, 0, 8'h00, 0, 0, 0, 0);
    step(1, 1, 0, 8'h00, 0, 0, 0, 0);
    chk("R11 flushed", fill, 0);

    for (int b = 0; b < 80; b++) begin
      logic en;
      logic [7:0] gc;
      logic [4:0] tl;
      en = ($urandom % 5) != 0;
      gc = ($urandom % 3 == 0) ? 8'($urandom % 6) : 8'h00;
      tl = 5'($urandom % 6);
      for (int c = 0; c < 40; c++)
        step(en, ($urandom % 20) != 0, $urandom % 2, 8'($urandom),
             ($urandom % 5) < 3, $urandom % 2, gc, tl);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule